// File: doc/BRIEF.md
# Keyed configuration item register port

This block is a memory-mapped slave that serves a small set of read-only configuration items. Each item is named by a 16-bit key. Software writes a key into the selector register and then pulls the item out one byte per access from the data register. An internal byte cursor advances after every read. Reads beyond the end of an item return zero and leave the cursor where it is.

A second, internal port lets an attached DMA engine work on the same cursor. The engine can select an item, fetch a byte, or move the cursor forward by an arbitrary count. A forward move stops at the item's length. Each of these requests is acknowledged one cycle later.

The built-in items are a four-byte signature under key 0x0000, a four-byte feature bitmap under key 0x0001, and a parameterised group of test items. Test item j has key TEST_BASE+j and length TEST_LEN+j, and its byte i is 0x80 + 16*j + i. Any other key behaves as an empty item.

Top module: `cfgitem_port`

## Requirements
- R1: Reset is synchronous and active low. It clears bus_rdata, dma_rd_data and dma_ack to 0, selects key 0x0000 and sets the cursor to 0. The first data read after reset therefore returns 0x51.
- R2: Key 0x0000 is four bytes long and reads 0x51, 0x45, 0x4D, 0x55 in that order.
- R3: Key 0x0001 is four bytes long and forms a little-endian 32-bit feature bitmap. Bit 1 equals the DMA_EN parameter and every other bit is 0, so with the default the bytes are 0x02, 0x00, 0x00, 0x00.
- R4: A bus write at byte offset 0x8 loads bus_wdata[15:0] as the key and rewinds the cursor to 0.
- R5: A bus read at any offset 0x0 to 0x7 places the byte at the cursor on bus_rdata one cycle later and advances the cursor by one. When the cursor is at or past the item length, the read returns 0x00 and the cursor does not move. The bus and DMA ports share this one cursor.
- R6: A key that names no item has length zero, so every read of it, by bus or DMA, returns 0x00.
- R7: Bus reads at offsets 0x8 and above return 0x00. Bus writes to any offset other than 0x8 are ignored. Neither kind of access moves the cursor.
- R8: A pulse on dma_sel_req loads dma_sel_key and rewinds the cursor to 0.
- R9: A pulse on dma_rd_req places the byte at the cursor on dma_rd_data one cycle later and advances the cursor, with the same end-of-item rule as R5. dma_rd_data changes only after a DMA read.
- R10: A pulse on dma_skip_req advances the cursor by dma_skip_len. The result saturates at the item length.
- R11: dma_ack is high for exactly the one cycle after each cycle that carries any DMA request, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (5) | Byte offset in the register window |
| bus_wdata | input | 16 | Write data, key in [15:0] |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| dma_sel_req | input | 1 | DMA select request |
| dma_sel_key | input | 16 | Key for the DMA select |
| dma_rd_req | input | 1 | DMA read-byte request |
| dma_rd_data | output | 8 | Byte from the last DMA read |
| dma_skip_req | input | 1 | DMA skip request |
| dma_skip_len | input | 16 | Byte count for the DMA skip |
| dma_ack | output | 1 | One-cycle acknowledge of a DMA request |

## Verification
The assertions assume that at most one cursor operation is requested per cycle: one DMA request or one bus access. When requests collide, the design applies a fixed priority (DMA select, DMA read, DMA skip, then the bus) and drops the losing operation. The checker's own rules assume that requests do not overlap. The stimulus issues each request as a single-cycle pulse with idle cycles in between, so it never presents two operations together. Skip counts cover an in-range move, a move that lands exactly on the last byte, and an oversized count that must saturate.

// File: rtl/cfgitem_pkg.sv
// Shared definitions for the keyed configuration item port.
// Assumes 16-bit keys; item contents are computed, never stored as tables.
package cfgitem_pkg;

    localparam int unsigned KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_SIG  = 16'h0000;
    localparam logic [KEY_W-1:0] KEY_FEAT = 16'h0001;
    localparam int unsigned SIG_LEN  = 4;
    localparam int unsigned FEAT_LEN = 4;

    // Cursor operation selected for the current cycle.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SEL  = 2'd1,
        OP_RD   = 2'd2,
        OP_SKIP = 2'd3
    } cur_op_e;

endpackage

// File: rtl/cfgitem_rom.sv
// Item store: maps (key, offset) to the item length and the raw byte at that offset.
// Purely combinational. Test items are built by a generate loop.
// Assumes TEST_BASE+NUM_TEST does not reach the fixed keys and TEST_LEN+NUM_TEST fits in OFF_W.
module cfgitem_rom
    import cfgitem_pkg::*;
#(
    parameter int unsigned OFF_W     = 8,
    parameter bit          DMA_EN    = 1'b1,
    parameter int unsigned NUM_TEST  = 2,
    parameter int unsigned TEST_BASE = 16'h0020,
    parameter int unsigned TEST_LEN  = 5
) (
    input  logic [KEY_W-1:0] key,
    input  logic [OFF_W-1:0] off,
    output logic [OFF_W-1:0] len,
    output logic [7:0]       data
);

    logic [NUM_TEST-1:0] t_hit;
    logic [OFF_W-1:0]    t_len  [NUM_TEST];
    logic [7:0]          t_byte [NUM_TEST];

    // One key match, length and byte generator per test item.
    for (genvar j = 0; j < NUM_TEST; j++) begin : g_item
        localparam logic [KEY_W-1:0] KEY_J  = KEY_W'(TEST_BASE + j);
        localparam logic [OFF_W-1:0] LEN_J  = OFF_W'(TEST_LEN + j);
        localparam logic [7:0]       BASE_J = 8'(8'h80 + 16 * j);
        assign t_hit[j]  = (key == KEY_J);
        assign t_len[j]  = LEN_J;
        assign t_byte[j] = BASE_J + 8'(off);
    end

    // Pick the length and byte of the item that the key names.
    always_comb begin
        len  = '0;
        data = 8'h00;
        if (key == KEY_SIG) begin
            len = OFF_W'(SIG_LEN);
            case (off[1:0])
                2'd0:    data = 8'h51;
                2'd1:    data = 8'h45;
                2'd2:    data = 8'h4D;
                default: data = 8'h55;
            endcase
        end else if (key == KEY_FEAT) begin
            len  = OFF_W'(FEAT_LEN);
            data = (off == '0) ? {6'b0, DMA_EN, 1'b0} : 8'h00;
        end else begin
            for (int j = 0; j < NUM_TEST; j++) begin
                if (t_hit[j]) begin
                    len  = t_len[j];
                    data = t_byte[j];
                end
            end
        end
    end

endmodule

// File: rtl/cfgitem_cursor.sv
// Holds the selected key and the byte cursor, and applies one operation per cycle.
// Reads stop at the item end; skips saturate at the item length.
// Assumes the item length comes combinationally from the store for the held key.
module cfgitem_cursor
    import cfgitem_pkg::*;
#(
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cur_op_e          op,
    input  logic [KEY_W-1:0] op_key,
    input  logic [15:0]      op_skip,
    input  logic [OFF_W-1:0] item_len,
    input  logic [7:0]       item_byte,
    output logic [KEY_W-1:0] key,
    output logic [OFF_W-1:0] off,
    output logic [7:0]       cur_byte
);

    localparam int unsigned SUM_W = ((OFF_W > 16) ? OFF_W : 16) + 1;

    logic             in_range;
    logic [SUM_W-1:0] skip_sum;
    logic [OFF_W-1:0] skip_next;

    // Byte under the cursor, zero once the cursor reaches the item end.
    always_comb begin
        in_range = (off < item_len);
        cur_byte = in_range ? item_byte : 8'h00;
    end

    // Saturating cursor target for a skip.
    always_comb begin
        skip_sum  = SUM_W'(off) + SUM_W'(op_skip);
        skip_next = (skip_sum > SUM_W'(item_len)) ? item_len : OFF_W'(skip_sum);
    end

    // Key and cursor update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key <= KEY_SIG;
            off <= '0;
        end else begin
            case (op)
                OP_SEL: begin
                    key <= op_key;
                    off <= '0;
                end
                OP_RD:   if (in_range) off <= off + 1'b1;
                OP_SKIP: off <= skip_next;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfgitem_busif.sv
// Register-window decode: the data register sits at offsets 0x0 to 0x7 and the selector at 0x8.
// Reads of other offsets return zero, and writes to them are dropped.
// Assumes single-cycle bus_req strobes; read data is registered.
module cfgitem_busif
    import cfgitem_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [15:0]      bus_wdata,
    input  logic             grant,
    input  logic [7:0]       cur_byte,
    output logic             sel_wr,
    output logic             data_rd,
    output logic [KEY_W-1:0] sel_key,
    output logic [7:0]       bus_rdata
);

    localparam logic [AW-1:0] DATA_END = AW'(8);
    localparam logic [AW-1:0] SEL_OFF  = AW'(8);

    // Decode the access type from the offset and direction.
    always_comb begin
        data_rd = bus_req && !bus_we && (bus_addr < DATA_END);
        sel_wr  = bus_req &&  bus_we && (bus_addr == SEL_OFF);
        sel_key = bus_wdata;
    end

    // Capture read data; unmapped or dropped reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_req && !bus_we)
            bus_rdata <= (data_rd && grant) ? cur_byte : 8'h00;
    end

endmodule

// File: rtl/cfgitem_port.sv
// Top of the keyed configuration item port: bus slave plus internal DMA-side port.
// Both ports share one key and cursor. One operation is applied per cycle,
// with fixed priority: DMA select, DMA read, DMA skip, bus selector write, bus data read.
module cfgitem_port
    import cfgitem_pkg::*;
#(
    parameter int unsigned AW        = 5,
    parameter int unsigned OFF_W     = 8,
    parameter bit          DMA_EN    = 1'b1,
    parameter int unsigned NUM_TEST  = 2,
    parameter int unsigned TEST_BASE = 16'h0020,
    parameter int unsigned TEST_LEN  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          dma_sel_req,
    input  logic [15:0]   dma_sel_key,
    input  logic          dma_rd_req,
    output logic [7:0]    dma_rd_data,
    input  logic          dma_skip_req,
    input  logic [15:0]   dma_skip_len,
    output logic          dma_ack
);

    logic             bus_sel_wr, bus_data_rd, bus_grant;
    logic [KEY_W-1:0] bus_key, cur_key, op_key;
    logic [OFF_W-1:0] cur_off, cur_len;
    logic [7:0]       rom_byte, cur_byte;
    cur_op_e          op;

    // Choose the single cursor operation for this cycle.
    always_comb begin
        op        = OP_NONE;
        op_key    = dma_sel_key;
        bus_grant = 1'b0;
        if (dma_sel_req)       op = OP_SEL;
        else if (dma_rd_req)   op = OP_RD;
        else if (dma_skip_req) op = OP_SKIP;
        else if (bus_sel_wr) begin
            op     = OP_SEL;
            op_key = bus_key;
        end else if (bus_data_rd) begin
            op        = OP_RD;
            bus_grant = 1'b1;
        end
    end

    cfgitem_busif #(.AW(AW)) u_busif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .grant     (bus_grant),
        .cur_byte  (cur_byte),
        .sel_wr    (bus_sel_wr),
        .data_rd   (bus_data_rd),
        .sel_key   (bus_key),
        .bus_rdata (bus_rdata)
    );

    cfgitem_rom #(
        .OFF_W(OFF_W), .DMA_EN(DMA_EN), .NUM_TEST(NUM_TEST),
        .TEST_BASE(TEST_BASE), .TEST_LEN(TEST_LEN)
    ) u_rom (
        .key  (cur_key),
        .off  (cur_off),
        .len  (cur_len),
        .data (rom_byte)
    );

    cfgitem_cursor #(.OFF_W(OFF_W)) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .op_key    (op_key),
        .op_skip   (dma_skip_len),
        .item_len  (cur_len),
        .item_byte (rom_byte),
        .key       (cur_key),
        .off       (cur_off),
        .cur_byte  (cur_byte)
    );

    // DMA-side read data and acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_rd_data <= 8'h00;
            dma_ack     <= 1'b0;
        end else begin
            dma_ack <= dma_sel_req || dma_rd_req || dma_skip_req;
            if (!dma_sel_req && dma_rd_req)
                dma_rd_data <= cur_byte;
        end
    end

endmodule

// File: rtl/cfgitem_port_chk.sv
// Protocol and state checks for cfgitem_port, attached with bind.
// Assumes at most one cursor operation is requested per cycle.
module cfgitem_port_chk #(
    parameter int unsigned AW    = 5,
    parameter int unsigned OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic [AW-1:0]    bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             dma_sel_req,
    input logic             dma_rd_req,
    input logic             dma_skip_req,
    input logic             dma_ack,
    input logic [7:0]       dma_rd_data,
    input logic [OFF_W-1:0] cur_off,
    input logic [OFF_W-1:0] cur_len
);

    logic any_dma, bus_sel, bus_dat;
    assign any_dma = dma_sel_req || dma_rd_req || dma_skip_req;
    assign bus_sel = bus_req && bus_we && (bus_addr == AW'(8));
    assign bus_dat = bus_req && !bus_we && (bus_addr < AW'(8));

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any_dma |=> dma_ack); // R11
    AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |-> $past(any_dma)); // R11
    AST_SEL_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_sel_req || (bus_sel && !any_dma)) |=> (cur_off == '0)); // R4
    AST_CURSOR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cur_off <= cur_len); // R10
    AST_END_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_dat && !any_dma) || (dma_rd_req && !dma_sel_req)) && (cur_off >= cur_len)
        |=> $stable(cur_off)); // R5
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (bus_addr >= AW'(8))) |=> (bus_rdata == 8'h00)); // R7
    AST_DMA_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rd_req |=> $stable(dma_rd_data)); // R9

endmodule

bind cfgitem_port cfgitem_port_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .dma_sel_req  (dma_sel_req),
    .dma_rd_req   (dma_rd_req),
    .dma_skip_req (dma_skip_req),
    .dma_ack      (dma_ack),
    .dma_rd_data  (dma_rd_data),
    .cur_off      (cur_off),
    .cur_len      (cur_len)
);

// File: tb/cfgitem_port_tb.sv
// Bench: a packed vector table walked by one loop, then directed reset and handshake tests.
module cfgitem_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        dma_sel_req = 1'b0, dma_rd_req = 1'b0, dma_skip_req = 1'b0;
    logic [15:0] dma_sel_key = '0, dma_skip_len = '0;
    logic [7:0]  dma_rd_data;
    logic        dma_ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cfgitem_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_sel_req(dma_sel_req), .dma_sel_key(dma_sel_key),
        .dma_rd_req(dma_rd_req), .dma_rd_data(dma_rd_data),
        .dma_skip_req(dma_skip_req), .dma_skip_len(dma_skip_len),
        .dma_ack(dma_ack)
    );

    // Kinds: 0 bus data read, 1 bus selector write, 2 DMA select, 3 DMA read,
    //        4 DMA skip, 5 bus write elsewhere, 6 bus read elsewhere.
    // Entry = {kind[2:0], arg[15:0], expected[7:0], requirement[3:0]}.
    localparam int NV = 34;
    localparam logic [30:0] VEC [NV] = '{
        {3'd0, 16'h0000, 8'h51, 4'd2},  // R2 signature byte 0 right after reset
        {3'd0, 16'h0003, 8'h45, 4'd2},  // R2 any offset 0x0..0x7 reads data
        {3'd0, 16'h0007, 8'h4D, 4'd2},  // R2
        {3'd0, 16'h0001, 8'h55, 4'd2},  // R2
        {3'd0, 16'h0000, 8'h00, 4'd5},  // R5 past end
        {3'd1, 16'h0001, 8'h00, 4'd4},  // R4 select feature bitmap
        {3'd0, 16'h0000, 8'h02, 4'd3},  // R3 bit 1 set
        {3'd0, 16'h0000, 8'h00, 4'd3},  // R3
        {3'd0, 16'h0000, 8'h00, 4'd3},  // R3
        {3'd0, 16'h0000, 8'h00, 4'd3},  // R3
        {3'd0, 16'h0000, 8'h00, 4'd5},  // R5 past end
        {3'd2, 16'h0020, 8'h00, 4'd8},  // R8 DMA select test item 0
        {3'd3, 16'h0000, 8'h80, 4'd9},  // R9
        {3'd0, 16'h0000, 8'h81, 4'd5},  // R5 shared cursor
        {3'd4, 16'h0002, 8'h00, 4'd10}, // R10 skip 2
        {3'd3, 16'h0000, 8'h84, 4'd9},  // R9 last byte
        {3'd3, 16'h0000, 8'h00, 4'd9},  // R9 past end
        {3'd1, 16'h0020, 8'h00, 4'd4},  // R4 reselect rewinds
        {3'd0, 16'h0000, 8'h80, 4'd4},  // R4
        {3'd5, 16'h0010, 8'h00, 4'd7},  // R7 write elsewhere
        {3'd0, 16'h0000, 8'h81, 4'd7},  // R7 cursor untouched
        {3'd6, 16'h0008, 8'h00, 4'd7},  // R7 selector reads zero
        {3'd0, 16'h0000, 8'h82, 4'd7},  // R7 cursor untouched
        {3'd4, 16'hFFFF, 8'h00, 4'd10}, // R10 oversized skip
        {3'd0, 16'h0000, 8'h00, 4'd10}, // R10 saturated at end
        {3'd2, 16'h0021, 8'h00, 4'd8},  // R8 select test item 1
        {3'd3, 16'h0000, 8'h90, 4'd8},  // R8 offset rewound
        {3'd1, 16'h1234, 8'h00, 4'd6},  // R6 unknown key
        {3'd0, 16'h0000, 8'h00, 4'd6},  // R6
        {3'd3, 16'h0000, 8'h00, 4'd6},  // R6
        {3'd1, 16'h0021, 8'h00, 4'd4},  // R4
        {3'd4, 16'h0005, 8'h00, 4'd10}, // R10 skip to last byte
        {3'd0, 16'h0000, 8'h95, 4'd10}, // R10
        {3'd6, 16'h0011, 8'h00, 4'd7}   // R7 upper window reads zero
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        dma_sel_req = 1'b0; dma_rd_req = 1'b0; dma_skip_req = 1'b0;
        dma_sel_key = '0; dma_skip_len = '0;
    endtask

    task automatic apply(input logic [2:0] kind, input logic [15:0] arg,
                         input logic [7:0] exp, input string tag);
        @(negedge clk);
        case (kind)
            3'd0: begin bus_req = 1'b1; bus_addr = arg[4:0]; end
            3'd1: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = 5'h08; bus_wdata = arg; end
            3'd2: begin dma_sel_req = 1'b1; dma_sel_key = arg; end
            3'd3: dma_rd_req = 1'b1;
            3'd4: begin dma_skip_req = 1'b1; dma_skip_len = arg; end
            3'd5: begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = arg[4:0]; bus_wdata = 16'hFFFF; end
            default: begin bus_req = 1'b1; bus_addr = arg[4:0]; end
        endcase
        @(negedge clk);
        clear_inputs();
        case (kind)
            3'd0, 3'd6: check(tag, bus_rdata, exp);
            3'd3: begin
                check(tag, dma_rd_data, exp);
                check("R11 ack", {7'b0, dma_ack}, 8'h01);
            end
            3'd2, 3'd4: check("R11 ack", {7'b0, dma_ack}, 8'h01);
            default: ;
        endcase
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 dma data after reset", dma_rd_data, 8'h00);
        check("R1 ack after reset", {7'b0, dma_ack}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][30:28], VEC[i][27:12], VEC[i][11:4],
                  $sformatf("R%0d vec%0d", VEC[i][3:0], i));
        end

        // R11: acknowledge lasts one cycle only.
        apply(3'd2, 16'h0020, 8'h00, "R11");
        @(negedge clk);
        check("R11 ack drops", {7'b0, dma_ack}, 8'h00);

        // R9: DMA data holds across bus reads.
        apply(3'd3, 16'h0000, 8'h80, "R9 dma read");
        apply(3'd0, 16'h0000, 8'h81, "R5 bus read");
        check("R9 dma data held", dma_rd_data, 8'h80);

        // R1: reset mid-run returns to the signature item at offset 0.
        apply(3'd1, 16'h0021, 8'h00, "R4");
        apply(3'd0, 16'h0000, 8'h90, "R5");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 rdata cleared", bus_rdata, 8'h00);
        check("R1 dma data cleared", dma_rd_data, 8'h00);
        apply(3'd0, 16'h0000, 8'h51, "R1 signature after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule